// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sits between the address generation of a 32-bit processor pipeline and its translation buffer. For every accepted request it looks at the top bits of the virtual address and the current privilege state. From these it decides whether the address is forbidden, mapped directly onto physical memory, or resolved through the translation buffer.

For a translated address, the block takes the lookup result from outside: hit, valid and dirty flags, plus the page frame number. It turns that result into either a physical address with permissions or a precise fault. On any fault it also computes the new values of the faulting-address register and of the page-number fields of the context and entry-high registers. The surrounding core can write these back in one step.

One response comes out one clock after each request, marked by a valid strobe. The response is either a successful translation or exactly one fault, never both.

Top module: `vaddr_seg_decoder`

## Requirements
- R1: Each cycle with `req_valid_i` high produces `resp_valid_o` high on the next cycle; a cycle without a request produces `resp_valid_o` low on the next cycle.
- R2: With `user_i` high, an address with bit 31 set faults with code 4 on a read and code 5 on a write, `mapped_o` low.
- R3: With `user_i` low and `erl_i` high, an address below 0x80000000 maps to itself with `perm_o` = 2'b11 (bit 0 read, bit 1 write), no fault and `mapped_o` low.
- R4: With `user_i` low, an address in 0x80000000..0x9FFFFFFF maps to the address minus 0x80000000 with `perm_o` = 2'b11, no fault and `mapped_o` low.
- R5: With `user_i` low, an address in 0xA0000000..0xBFFFFFFF maps to the address minus 0xA0000000 with `perm_o` = 2'b11, no fault and `mapped_o` low.
- R6: Addresses below 0x80000000 (user mode, or kernel with `erl_i` low) and kernel addresses at or above 0xC0000000 set `mapped_o`. On a hit to a valid entry that is either read or dirty, `paddr_o` = {`tlb_pfn_i`, address bits 11..0} and `perm_o` = {dirty, 1}.
- R7: A mapped access with `tlb_hit_i` low faults with code 2 on a read and code 3 on a write, with `refill_o` high.
- R8: A mapped access that hits an entry with `tlb_valid_i` low faults with code 2 on a read and code 3 on a write, with `refill_o` low.
- R9: A mapped write that hits a valid entry with `tlb_dirty_i` low faults with code 1, with `refill_o` low.
- R10: On a fault, the outputs are `badvaddr_o` = address, `context_o` = {address[31:12], `context_i`[11:0]}, `entryhi_o` = {address[31:12], `entryhi_i`[11:0]}, `paddr_o` = 0 and `perm_o` = 0. Without a fault, `badvaddr_o` = 0, `exc_code_o` = 0, and `context_o`/`entryhi_o` equal `context_i`/`entryhi_i`.
- R11: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| vaddr_i | input | 32 | Virtual address |
| write_i | input | 1 | 1 = store, 0 = load |
| user_i | input | 1 | User privilege |
| erl_i | input | 1 | Error level active |
| tlb_hit_i | input | 1 | Lookup found a matching entry |
| tlb_valid_i | input | 1 | Matching page is valid |
| tlb_dirty_i | input | 1 | Matching page is writable |
| tlb_pfn_i | input | 20 | Page frame number from lookup |
| context_i | input | 32 | Current context register |
| entryhi_i | input | 32 | Current entry-high register |
| resp_valid_o | output | 1 | Response strobe |
| mapped_o | output | 1 | Address went through the lookup |
| fault_o | output | 1 | Request faulted |
| exc_code_o | output | 5 | Exception code |
| refill_o | output | 1 | Fault was a lookup miss |
| perm_o | output | 2 | {write, read} permission |
| paddr_o | output | 32 | Physical address |
| badvaddr_o | output | 32 | Faulting address value |
| context_o | output | 32 | Updated context value |
| entryhi_o | output | 32 | Updated entry-high value |

## Verification
The bound assertions watch several properties on every cycle. They check the request-to-response pairing and the address-error rule for user mode. They check the identity mapping under the error level and the first direct segment's offset. They check that a fault carries zero address and permission together with the full faulting address, and that a lookup miss on a mapped access always reports a refill. Four outcomes depend on the particular mix of inputs and are shown only by the bench's sweep: the second direct segment, the distinction between an invalid entry and a write to a clean page, the load/store split of the exception codes for lookup faults, and the pass-through of the context and entry-high registers.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  localparam int unsigned EXC_W = 5;

  typedef enum logic [1:0] {
    KIND_TLB      = 2'd0,
    KIND_DIRECT   = 2'd1,
    KIND_ADDR_ERR = 2'd2
  } vseg_kind_e;

  localparam logic [EXC_W-1:0] EXC_NONE = 5'd0;
  localparam logic [EXC_W-1:0] EXC_MOD  = 5'd1;
  localparam logic [EXC_W-1:0] EXC_TLBL = 5'd2;
  localparam logic [EXC_W-1:0] EXC_TLBS = 5'd3;
  localparam logic [EXC_W-1:0] EXC_ADEL = 5'd4;
  localparam logic [EXC_W-1:0] EXC_ADES = 5'd5;
endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
  import vseg_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] vaddr_i,
  input  logic          user_i,
  input  logic          erl_i,
  output vseg_kind_e    kind_o,
  output logic [AW-1:0] direct_o
);
  logic [2:0] top3;
  assign top3 = vaddr_i[AW-1 -: 3];

  always_comb begin
    kind_o   = KIND_TLB;
    direct_o = vaddr_i;
    if (user_i && top3[2]) begin
      kind_o = KIND_ADDR_ERR;
    end else begin
      unique case (top3)
        3'b100: begin
          kind_o           = KIND_DIRECT;
          direct_o[AW-1]   = 1'b0;
        end
        3'b101: begin
          kind_o             = KIND_DIRECT;
          direct_o[AW-1 -: 3] = 3'b000;
        end
        3'b110, 3'b111: kind_o = KIND_TLB;
        default: if (!user_i && erl_i) kind_o = KIND_DIRECT;
      endcase
    end
  end
endmodule

// File: rtl/vseg_tlb_check.sv
module vseg_tlb_check
  import vseg_pkg::*;
(
  input  vseg_kind_e       kind_i,
  input  logic             write_i,
  input  logic             tlb_hit_i,
  input  logic             tlb_valid_i,
  input  logic             tlb_dirty_i,
  output logic             mapped_o,
  output logic             fault_o,
  output logic [EXC_W-1:0] exc_o,
  output logic             refill_o,
  output logic [1:0]       perm_o
);
  logic [EXC_W-1:0] tlb_exc;
  assign tlb_exc = write_i ? EXC_TLBS : EXC_TLBL;

  always_comb begin
    mapped_o = 1'b0;
    fault_o  = 1'b0;
    exc_o    = EXC_NONE;
    refill_o = 1'b0;
    perm_o   = 2'b00;
    unique case (kind_i)
      KIND_ADDR_ERR: begin
        fault_o = 1'b1;
        exc_o   = write_i ? EXC_ADES : EXC_ADEL;
      end
      KIND_DIRECT: perm_o = 2'b11;
      default: begin
        mapped_o = 1'b1;
        if (!tlb_hit_i) begin
          fault_o  = 1'b1;
          exc_o    = tlb_exc;
          refill_o = 1'b1;
        end else if (!tlb_valid_i) begin
          fault_o = 1'b1;
          exc_o   = tlb_exc;
        end else if (write_i && !tlb_dirty_i) begin
          fault_o = 1'b1;
          exc_o   = EXC_MOD;
        end else begin
          perm_o = {tlb_dirty_i, 1'b1};
        end
      end
    endcase
  end
endmodule

// File: rtl/vseg_fault_pack.sv
module vseg_fault_pack #(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic          fault_i,
  input  logic [AW-1:0] vaddr_i,
  input  logic [AW-1:0] context_i,
  input  logic [AW-1:0] entryhi_i,
  output logic [AW-1:0] badvaddr_o,
  output logic [AW-1:0] context_o,
  output logic [AW-1:0] entryhi_o
);
  localparam int unsigned VPN_W = AW - OFF_W;
  logic [VPN_W-1:0] vpn;
  assign vpn = vaddr_i[AW-1 -: VPN_W];

  always_comb begin
    if (fault_i) begin
      badvaddr_o = vaddr_i;
      context_o  = {vpn, context_i[OFF_W-1:0]};
      entryhi_o  = {vpn, entryhi_i[OFF_W-1:0]};
    end else begin
      badvaddr_o = '0;
      context_o  = context_i;
      entryhi_o  = entryhi_i;
    end
  end
endmodule

// File: rtl/vaddr_seg_decoder.sv
module vaddr_seg_decoder
  import vseg_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [AW-1:0]       vaddr_i,
  input  logic                write_i,
  input  logic                user_i,
  input  logic                erl_i,
  input  logic                tlb_hit_i,
  input  logic                tlb_valid_i,
  input  logic                tlb_dirty_i,
  input  logic [AW-OFF_W-1:0] tlb_pfn_i,
  input  logic [AW-1:0]       context_i,
  input  logic [AW-1:0]       entryhi_i,
  output logic                resp_valid_o,
  output logic                mapped_o,
  output logic                fault_o,
  output logic [EXC_W-1:0]    exc_code_o,
  output logic                refill_o,
  output logic [1:0]          perm_o,
  output logic [AW-1:0]       paddr_o,
  output logic [AW-1:0]       badvaddr_o,
  output logic [AW-1:0]       context_o,
  output logic [AW-1:0]       entryhi_o
);
  vseg_kind_e       kind;
  logic [AW-1:0]    direct_pa;
  logic             mapped_d, fault_d, refill_d;
  logic [EXC_W-1:0] exc_d;
  logic [1:0]       perm_d;
  logic [AW-1:0]    paddr_d, badv_d, ctx_d, ehi_d;

  vseg_classify #(.AW(AW)) u_classify (
    .vaddr_i (vaddr_i),
    .user_i  (user_i),
    .erl_i   (erl_i),
    .kind_o  (kind),
    .direct_o(direct_pa)
  );

  vseg_tlb_check u_check (
    .kind_i     (kind),
    .write_i    (write_i),
    .tlb_hit_i  (tlb_hit_i),
    .tlb_valid_i(tlb_valid_i),
    .tlb_dirty_i(tlb_dirty_i),
    .mapped_o   (mapped_d),
    .fault_o    (fault_d),
    .exc_o      (exc_d),
    .refill_o   (refill_d),
    .perm_o     (perm_d)
  );

  vseg_fault_pack #(.AW(AW), .OFF_W(OFF_W)) u_pack (
    .fault_i   (fault_d),
    .vaddr_i   (vaddr_i),
    .context_i (context_i),
    .entryhi_i (entryhi_i),
    .badvaddr_o(badv_d),
    .context_o (ctx_d),
    .entryhi_o (ehi_d)
  );

  always_comb begin
    if (fault_d)                paddr_d = '0;
    else if (kind == KIND_DIRECT) paddr_d = direct_pa;
    else                        paddr_d = {tlb_pfn_i, vaddr_i[OFF_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      mapped_o     <= 1'b0;
      fault_o      <= 1'b0;
      exc_code_o   <= '0;
      refill_o     <= 1'b0;
      perm_o       <= '0;
      paddr_o      <= '0;
      badvaddr_o   <= '0;
      context_o    <= '0;
      entryhi_o    <= '0;
    end else begin
      resp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        mapped_o   <= mapped_d;
        fault_o    <= fault_d;
        exc_code_o <= exc_d;
        refill_o   <= refill_d;
        perm_o     <= perm_d;
        paddr_o    <= paddr_d;
        badvaddr_o <= badv_d;
        context_o  <= ctx_d;
        entryhi_o  <= ehi_d;
      end
    end
  end
endmodule

// File: rtl/vseg_checker.sv
module vseg_checker
  import vseg_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [AW-1:0]    vaddr_i,
  input logic             write_i,
  input logic             user_i,
  input logic             erl_i,
  input logic             tlb_hit_i,
  input logic             resp_valid_o,
  input logic             mapped_o,
  input logic             fault_o,
  input logic [EXC_W-1:0] exc_code_o,
  input logic             refill_o,
  input logic [1:0]       perm_o,
  input logic [AW-1:0]    paddr_o,
  input logic [AW-1:0]    badvaddr_o
);
  AST_ONE_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o); // R1
  AST_USER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && user_i && vaddr_i[AW-1] |=>
      fault_o && !mapped_o && exc_code_o == ($past(write_i) ? EXC_ADES : EXC_ADEL)); // R2
  AST_ERL_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !user_i && erl_i && !vaddr_i[AW-1] |=>
      !fault_o && !mapped_o && paddr_o == $past(vaddr_i)); // R3
  AST_KSEG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !user_i && vaddr_i[AW-1 -: 3] == 3'b100 |=>
      paddr_o == {1'b0, $past(vaddr_i[AW-2:0])} && perm_o == 2'b11); // R4
  AST_MISS_REFILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !tlb_hit_i |=> !mapped_o || (refill_o && fault_o)); // R7
  AST_FAULT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && fault_o |-> perm_o == 2'b00 && paddr_o == '0); // R10
  AST_BADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> !fault_o || badvaddr_o == $past(vaddr_i)); // R10
endmodule

bind vaddr_seg_decoder vseg_checker #(.AW(AW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .vaddr_i     (vaddr_i),
  .write_i     (write_i),
  .user_i      (user_i),
  .erl_i       (erl_i),
  .tlb_hit_i   (tlb_hit_i),
  .resp_valid_o(resp_valid_o),
  .mapped_o    (mapped_o),
  .fault_o     (fault_o),
  .exc_code_o  (exc_code_o),
  .refill_o    (refill_o),
  .perm_o      (perm_o),
  .paddr_o     (paddr_o),
  .badvaddr_o  (badvaddr_o)
);

// File: tb/vaddr_seg_decoder_tb_top.sv
module vaddr_seg_decoder_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic        write_i = 1'b0, user_i = 1'b0, erl_i = 1'b0;
  logic        tlb_hit_i = 1'b0, tlb_valid_i = 1'b0, tlb_dirty_i = 1'b0;
  logic [19:0] tlb_pfn_i = '0;
  logic [31:0] context_i = '0, entryhi_i = '0;
  logic        resp_valid_o, mapped_o, fault_o, refill_o;
  logic [4:0]  exc_code_o;
  logic [1:0]  perm_o;
  logic [31:0] paddr_o, badvaddr_o, context_o, entryhi_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  vaddr_seg_decoder dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, e_pa, e_badv, e_ctx, e_ehi;
    logic [4:0]  e_exc;
    logic [1:0]  e_perm;
    logic        e_fault, e_ref, e_map;
    string       tag;

    repeat (3) @(negedge clk_i);
    // R11: outputs zero during reset
    chk({resp_valid_o, mapped_o, fault_o, refill_o, exc_code_o, perm_o, paddr_o,
         badvaddr_o, context_o, entryhi_o} == '0, "R11",
        {paddr_o, badvaddr_o, context_o, entryhi_o}, 128'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(resp_valid_o == 1'b0, "R1 idle", resp_valid_o, 0);

    for (int nib = 0; nib < 16; nib++) begin
      for (int combo = 0; combo < 64; combo++) begin
        a           = {nib[3:0], 28'h0ABC123 + 28'(combo * 32'h0011F35)};
        write_i     = combo[0];
        user_i      = combo[1];
        erl_i       = combo[2];
        tlb_hit_i   = combo[3];
        tlb_valid_i = combo[4];
        tlb_dirty_i = combo[5];
        tlb_pfn_i   = 20'h5A5A5 ^ 20'(combo * 7 + nib);
        context_i   = 32'hC0FFE000 + 32'(combo * 33);
        entryhi_i   = 32'h12345000 ^ 32'(combo * 131 + nib);
        vaddr_i     = a;

        e_fault = 0; e_ref = 0; e_map = 0; e_exc = 0; e_perm = 0; e_pa = 0;
        if (user_i && a[31]) begin
          e_fault = 1; e_exc = write_i ? 5'd5 : 5'd4; tag = "R2";
        end else if (!a[31] && !user_i && erl_i) begin
          e_pa = a; e_perm = 2'b11; tag = "R3";
        end else if (a[31:29] == 3'b100) begin
          e_pa = a - 32'h80000000; e_perm = 2'b11; tag = "R4";
        end else if (a[31:29] == 3'b101) begin
          e_pa = a - 32'hA0000000; e_perm = 2'b11; tag = "R5";
        end else begin
          e_map = 1;
          if (!tlb_hit_i) begin
            e_fault = 1; e_ref = 1; e_exc = write_i ? 5'd3 : 5'd2; tag = "R7";
          end else if (!tlb_valid_i) begin
            e_fault = 1; e_exc = write_i ? 5'd3 : 5'd2; tag = "R8";
          end else if (write_i && !tlb_dirty_i) begin
            e_fault = 1; e_exc = 5'd1; tag = "R9";
          end else begin
            e_pa = {tlb_pfn_i, a[11:0]}; e_perm = {tlb_dirty_i, 1'b1}; tag = "R6";
          end
        end
        e_badv = e_fault ? a : 32'h0;
        e_ctx  = e_fault ? {a[31:12], context_i[11:0]} : context_i;
        e_ehi  = e_fault ? {a[31:12], entryhi_i[11:0]} : entryhi_i;

        req_valid_i = 1'b1;
        @(negedge clk_i);
        req_valid_i = 1'b0;
        chk(resp_valid_o == 1'b1, "R1 resp", resp_valid_o, 1);
        chk({mapped_o, fault_o, refill_o, exc_code_o, perm_o, paddr_o} ==
            {e_map, e_fault, e_ref, e_exc, e_perm, e_pa}, tag,
            {mapped_o, fault_o, refill_o, exc_code_o, perm_o, paddr_o},
            {e_map, e_fault, e_ref, e_exc, e_perm, e_pa});
        // R10: fault register values
        chk({badvaddr_o, context_o, entryhi_o} == {e_badv, e_ctx, e_ehi}, "R10",
            {badvaddr_o, context_o, entryhi_o}, {e_badv, e_ctx, e_ehi});
        @(negedge clk_i);
        chk(resp_valid_o == 1'b0, "R1 no-req", resp_valid_o, 0);
      end
    end
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule